// File: doc/BRIEF.md
# Sync-Loss PWM Output Gating Supervisor

This block sits between a free-running PWM timer and the pins and event logic that the timer drives. It watches an external synchronisation pulse together with the timer's counter events: counter at zero, compare A and compare B. For every sync pulse it receives, it lets exactly one PWM cycle through, and compare B marks the end of that cycle. While the block is in pass-through, the two PWM phases reach the outputs unchanged. Compare events reach the trigger outputs that start interrupts or ADC conversions only while a sync is outstanding.

When a sync is missing, the block holds both outputs low. This can happen because compare B arrives with no sync pending, or because no sync lands inside a programmable window that opens at counter-equals-zero. In that case the block also latches a trip. The timer may keep counting during a trip, but none of its matches can raise an output or fire a trigger until software pulses a clear input. A two-bit status output reports the current mode.

Top module: `pwm_sync_gate`

## Requirements
- R1: After synchronous reset, `mode_o` is 0 (forced low), `trip_o` is 0, and both PWM outputs are 0 whatever the PWM inputs are.
- R2: A sync pulse sampled while not tripped sets `mode_o` to 1 (pass-through) from the next cycle. While `mode_o` is 1, `pwm_a_o` equals `pwm_a_i` and `pwm_b_o` equals `pwm_b_i` in the same cycle.
- R3: A compare-B event sampled in pass-through with no sync in the same cycle returns `mode_o` to 0 in the next cycle.
- R4: A compare-B event sampled in forced-low with no sync in the same cycle sets `mode_o` to 2 (tripped) and `trip_o` to 1 from the next cycle.
- R5: `cmpa_trig_o` and `cmpb_trig_o` follow their compare inputs in the same cycle only when the block is not tripped and either `mode_o` is 1 or a sync is present in that cycle. Otherwise they are 0. A compare-A event never changes the mode.
- R6: When a sync and a compare B arrive in the same cycle, the sync is taken first. The compare-B trigger is forwarded, and the block is in pass-through in the next cycle.
- R7: While tripped, both PWM outputs and both trigger outputs are 0, and sync pulses are ignored.
- R8: `trip_o` stays 1 until a `trip_clr_i` pulse, which returns the block to mode 0. `trip_clr_i` has no effect when the block is not tripped.
- R9: A counter-zero event sampled at edge E0, with `win_len_i` = W > 0, opens a window. If no sync is sampled at any of edges E0 to EW, the block is tripped from the cycle after EW. A sync at any of those edges closes the window with no trip.
- R10: With `win_len_i` = 0, counter-zero events open no window and never cause a trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | External sync pulse, one cycle |
| ctr_zero_i | input | 1 | Timer counter equals zero |
| cmpa_i | input | 1 | Timer compare-A match |
| cmpb_i | input | 1 | Timer compare-B match, ends the enabled cycle |
| pwm_a_i | input | 1 | Raw PWM phase A |
| pwm_b_i | input | 1 | Raw PWM phase B |
| win_len_i | input | WIN_W | Supervision window length in clocks, 0 disables |
| trip_clr_i | input | 1 | Software clear of the latched trip |
| pwm_a_o | output | 1 | Gated PWM phase A |
| pwm_b_o | output | 1 | Gated PWM phase B |
| cmpa_trig_o | output | 1 | Gated compare-A trigger |
| cmpb_trig_o | output | 1 | Gated compare-B trigger |
| trip_o | output | 1 | Latched trip flag |
| mode_o | output | 2 | 0 forced low, 1 pass-through, 2 tripped |

## Verification
A wrong mode register shows up at once. The PWM outputs and triggers are masked combinationally from it, so a spurious pass-through or a lost sync changes the phases and triggers in the same cycle that `mode_o` changes, one edge after the causing event. A window counter that is off by one only shows at the exact expiry edge. The bench therefore checks the mode one cycle before and one cycle after edge EW. A missed trip stays hidden until the next compare B reaches the forced-low mode.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;

    typedef enum logic [1:0] {
        MODE_LOW  = 2'd0,
        MODE_PASS = 2'd1,
        MODE_TRIP = 2'd2
    } gate_mode_e;

    typedef struct packed {
        logic sync;
        logic zero;
        logic cmpa;
        logic cmpb;
    } tmr_evt_s;

    function automatic logic mode_allows(input gate_mode_e m, input logic sync);
        return (m != MODE_TRIP) && ((m == MODE_PASS) || sync);
    endfunction

endpackage

// File: rtl/sync_window_timer.sv
module sync_window_timer #(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             armed_ok,
    input  logic             zero,
    input  logic             sync,
    input  logic [WIN_W-1:0] win_len,
    output logic             expire
);
    logic             open_q;
    logic [WIN_W-1:0] cnt_q;

    assign expire = open_q && !sync && (cnt_q == WIN_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !armed_ok) begin
            open_q <= 1'b0;
            cnt_q  <= '0;
        end else if (zero && !sync && (win_len != '0)) begin
            open_q <= 1'b1;
            cnt_q  <= win_len;
        end else if (open_q) begin
            if (sync || cnt_q == WIN_W'(1)) begin
                open_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - WIN_W'(1);
            end
        end
    end
endmodule

// File: rtl/sync_gate_fsm.sv
module sync_gate_fsm
    import pwm_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  tmr_evt_s   evt,
    input  logic       expire,
    input  logic       trip_clr,
    output gate_mode_e mode
);
    gate_mode_e mode_d;

    always_comb begin
        mode_d = mode;
        if (mode == MODE_TRIP) begin
            if (trip_clr) mode_d = MODE_LOW;
        end else if (expire) begin
            mode_d = MODE_TRIP;
        end else if (evt.sync) begin
            mode_d = MODE_PASS;
        end else if (evt.cmpb) begin
            mode_d = (mode == MODE_PASS) ? MODE_LOW : MODE_TRIP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode <= MODE_LOW;
        else     mode <= mode_d;
    end
endmodule

// File: rtl/gate_mask.sv
module gate_mask #(
    parameter int N = 2
) (
    input  logic         en,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        assign dout[i] = din[i] & en;
    end
endmodule

// File: rtl/pwm_sync_gate.sv
module pwm_sync_gate
    import pwm_gate_pkg::*;
#(
    parameter int WIN_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_i,
    input  logic             ctr_zero_i,
    input  logic             cmpa_i,
    input  logic             cmpb_i,
    input  logic             pwm_a_i,
    input  logic             pwm_b_i,
    input  logic [WIN_W-1:0] win_len_i,
    input  logic             trip_clr_i,
    output logic             pwm_a_o,
    output logic             pwm_b_o,
    output logic             cmpa_trig_o,
    output logic             cmpb_trig_o,
    output logic             trip_o,
    output logic [1:0]       mode_o
);
    localparam int NPH = 2;

    tmr_evt_s   evt;
    gate_mode_e mode;
    logic       expire;
    logic [NPH-1:0] ph_out;
    logic [1:0]     trig_out;

    assign evt = '{sync: sync_i, zero: ctr_zero_i, cmpa: cmpa_i, cmpb: cmpb_i};

    sync_window_timer #(.WIN_W(WIN_W)) i_timer (
        .clk     (clk),
        .rst     (rst),
        .armed_ok(mode != MODE_TRIP),
        .zero    (evt.zero),
        .sync    (evt.sync),
        .win_len (win_len_i),
        .expire  (expire)
    );

    sync_gate_fsm i_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .expire  (expire),
        .trip_clr(trip_clr_i),
        .mode    (mode)
    );

    gate_mask #(.N(NPH)) i_ph_mask (
        .en  (mode == MODE_PASS),
        .din ({pwm_b_i, pwm_a_i}),
        .dout(ph_out)
    );

    gate_mask #(.N(2)) i_trig_mask (
        .en  (mode_allows(mode, evt.sync)),
        .din ({evt.cmpb, evt.cmpa}),
        .dout(trig_out)
    );

    assign pwm_a_o     = ph_out[0];
    assign pwm_b_o     = ph_out[1];
    assign cmpa_trig_o = trig_out[0];
    assign cmpb_trig_o = trig_out[1];
    assign trip_o      = (mode == MODE_TRIP);
    assign mode_o      = mode;
endmodule

// File: rtl/pwm_sync_gate_chk.sv
module pwm_sync_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       sync_i,
    input logic       cmpa_i,
    input logic       cmpb_i,
    input logic       trip_clr_i,
    input logic       pwm_a_o,
    input logic       pwm_b_o,
    input logic       cmpa_trig_o,
    input logic       cmpb_trig_o,
    input logic       trip_o,
    input logic [1:0] mode_o
);
    p_low_unless_pass_r7: assert property (@(posedge clk) disable iff (rst)
        (mode_o != 2'd1) |-> (!pwm_a_o && !pwm_b_o));

    p_sync_enables_r2: assert property (@(posedge clk) disable iff (rst)
        (sync_i && !trip_o) |=> (mode_o == 2'd1));

    p_cmpb_nosync_trips_r4: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'd0 && cmpb_i && !sync_i) |=> trip_o);

    p_trip_blocks_r5: assert property (@(posedge clk) disable iff (rst)
        trip_o |-> (!cmpa_trig_o && !cmpb_trig_o));

    p_flag_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (trip_o && !trip_clr_i) |=> trip_o);

    p_clear_returns_r8: assert property (@(posedge clk) disable iff (rst)
        (trip_o && trip_clr_i) |=> (mode_o == 2'd0));

    p_same_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        (sync_i && cmpb_i && !trip_o) |-> cmpb_trig_o);
endmodule

bind pwm_sync_gate pwm_sync_gate_chk i_chk (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_i),
    .cmpa_i     (cmpa_i),
    .cmpb_i     (cmpb_i),
    .trip_clr_i (trip_clr_i),
    .pwm_a_o    (pwm_a_o),
    .pwm_b_o    (pwm_b_o),
    .cmpa_trig_o(cmpa_trig_o),
    .cmpb_trig_o(cmpb_trig_o),
    .trip_o     (trip_o),
    .mode_o     (mode_o)
);

// File: tb/test_pwm_sync_gate.sv
module test_pwm_sync_gate;
    localparam int WIN_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_i = 0, ctr_zero_i = 0, cmpa_i = 0, cmpb_i = 0;
    logic pwm_a_i = 0, pwm_b_i = 0, trip_clr_i = 0;
    logic [WIN_W-1:0] win_len_i = '0;
    logic pwm_a_o, pwm_b_o, cmpa_trig_o, cmpb_trig_o, trip_o;
    logic [1:0] mode_o;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_sync_gate #(.WIN_W(WIN_W)) i_pwm_sync_gate (
        .clk(clk), .rst(rst), .sync_i(sync_i), .ctr_zero_i(ctr_zero_i),
        .cmpa_i(cmpa_i), .cmpb_i(cmpb_i), .pwm_a_i(pwm_a_i), .pwm_b_i(pwm_b_i),
        .win_len_i(win_len_i), .trip_clr_i(trip_clr_i),
        .pwm_a_o(pwm_a_o), .pwm_b_o(pwm_b_o), .cmpa_trig_o(cmpa_trig_o),
        .cmpb_trig_o(cmpb_trig_o), .trip_o(trip_o), .mode_o(mode_o)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset_r1();
        pwm_a_i = 1; pwm_b_i = 1;
        tick(); tick();
        rst = 0;
        #1;
        check("R1", "mode", mode_o, 0);
        check("R1", "trip", trip_o, 0);
        check("R1", "pwm", {pwm_a_o, pwm_b_o}, 0);
    endtask

    task automatic t_sync_pass_r2();
        sync_i = 1; tick(); sync_i = 0;
        check("R2", "mode", mode_o, 1);
        pwm_a_i = 1; pwm_b_i = 0; #1;
        check("R2", "pwm a1b0", {pwm_a_o, pwm_b_o}, 2);
        pwm_a_i = 0; pwm_b_i = 1; #1;
        check("R2", "pwm a0b1", {pwm_a_o, pwm_b_o}, 1);
    endtask

    task automatic t_cycle_end_r3();
        cmpa_i = 1; #1;
        check("R5", "cmpa fwd in pass", cmpa_trig_o, 1);
        tick(); cmpa_i = 0;
        check("R5", "cmpa keeps mode", mode_o, 1);
        cmpb_i = 1; #1;
        check("R5", "cmpb fwd in pass", cmpb_trig_o, 1);
        tick(); cmpb_i = 0;
        check("R3", "mode after cmpb", mode_o, 0);
        pwm_a_i = 1; pwm_b_i = 1; #1;
        check("R3", "pwm low", {pwm_a_o, pwm_b_o}, 0);
    endtask

    task automatic t_blocked_r5();
        cmpa_i = 1; #1;
        check("R5", "cmpa blocked low", cmpa_trig_o, 0);
        tick(); cmpa_i = 0;
        check("R5", "cmpa no trip", mode_o, 0);
    endtask

    task automatic t_cmpb_trip_r4();
        cmpb_i = 1; #1;
        check("R5", "cmpb blocked low", cmpb_trig_o, 0);
        tick(); cmpb_i = 0;
        check("R4", "mode", mode_o, 2);
        check("R4", "trip", trip_o, 1);
    endtask

    task automatic t_tripped_r7();
        sync_i = 1; cmpa_i = 1; cmpb_i = 1; #1;
        check("R7", "cmpa trig", cmpa_trig_o, 0);
        check("R7", "cmpb trig", cmpb_trig_o, 0);
        tick(); sync_i = 0; cmpa_i = 0; cmpb_i = 0;
        check("R7", "sync ignored", mode_o, 2);
        check("R7", "pwm low", {pwm_a_o, pwm_b_o}, 0);
        tick();
        check("R8", "flag held", trip_o, 1);
    endtask

    task automatic t_clear_r8();
        trip_clr_i = 1; tick(); trip_clr_i = 0;
        check("R8", "mode after clear", mode_o, 0);
        check("R8", "flag cleared", trip_o, 0);
    endtask

    task automatic t_same_cycle_r6();
        sync_i = 1; cmpb_i = 1; #1;
        check("R6", "cmpb fwd", cmpb_trig_o, 1);
        tick(); sync_i = 0; cmpb_i = 0;
        check("R6", "mode", mode_o, 1);
        trip_clr_i = 1; tick(); trip_clr_i = 0;
        check("R8", "clear no effect", mode_o, 1);
        cmpb_i = 1; tick(); cmpb_i = 0;
        check("R3", "back to low", mode_o, 0);
    endtask

    task automatic t_window_r9();
        win_len_i = 5;
        ctr_zero_i = 1; tick(); ctr_zero_i = 0;
        for (int k = 1; k <= 3; k++) tick();
        sync_i = 1; tick(); sync_i = 0;
        check("R9", "sync in window", mode_o, 1);
        for (int k = 0; k < 8; k++) tick();
        check("R9", "no trip after sync", trip_o, 0);
        ctr_zero_i = 1; tick(); ctr_zero_i = 0;
        for (int k = 1; k <= 4; k++) tick();
        check("R9", "before expiry", trip_o, 0);
        tick();
        check("R9", "at expiry", trip_o, 1);
        trip_clr_i = 1; tick(); trip_clr_i = 0;
    endtask

    task automatic t_window_off_r10();
        win_len_i = 0;
        ctr_zero_i = 1; tick(); ctr_zero_i = 0;
        for (int k = 0; k < 20; k++) tick();
        check("R10", "no trip", trip_o, 0);
        check("R10", "mode", mode_o, 0);
    endtask

    initial begin
        t_reset_r1();
        t_sync_pass_r2();
        t_cycle_end_r3();
        t_blocked_r5();
        t_cmpb_trip_r4();
        t_tripped_r7();
        t_clear_r8();
        t_same_cycle_r6();
        t_window_r9();
        t_window_off_r10();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule